// File: doc/BRIEF.md
# Fractional-ratio tick generator

This block turns a fast clock into a stream of one-cycle enable pulses. Their average rate is exactly b/a of the clock rate, where a and b are integers with 0 < b < a. The ratio does not have to be an integer. Each cycle a signed error register is tested against zero. When it is not negative, the block emits a pulse and adds b − a. When it is negative, it adds b and emits nothing. The spacing between pulses varies by at most one clock period, but the pulse count never drifts from the exact ratio.

The ratio pair comes from parameters at reset. It can be replaced at run time by presenting a new pair with a load strobe. A load with an invalid pair is ignored. The output is registered, so logic downstream uses it as a clock enable and does not clock on it.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset, `tick_o` is low and the error register is zero. The pair in use is the parameter default (`DEF_A`, `DEF_B`), so the first evaluation after reset ticks.
- R2: Evaluations are numbered k = 0, 1, … from reset or an accepted load. If the error register is not negative at evaluation k, the block adds b − a and `tick_o` is high in the following cycle. Otherwise it adds b and `tick_o` is low in the following cycle.
- R3: The error register is RATIO_W+1 bits, two's complement. It always stays within [b − a, b − 1], so it never overflows.
- R4: Evaluation k ticks exactly when k = 0 or floor(k·b/a) > floor((k−1)·b/a). Any a consecutive evaluations counted from reset or a load therefore hold exactly b ticks.
- R5: The distance between two consecutive ticks is always floor(a/b) or ceil(a/b) cycles.
- R6: A load with 0 < b < a does three things: it captures the pair, it clears the error register, and it forces `tick_o` low in the cycle after the load edge. The next edge is evaluation 0 of the new pair.
- R7: A load with b = 0 or b ≥ a has no effect. The pair is kept, the error register is not cleared, and the tick sequence continues as if no load had happened.
- R8: When 2·b ≤ a, `tick_o` is never high for two consecutive cycles.
- R9: With the default parameters (RATIO_W = 24, a = 14,152,300, b = 24), the first evaluation after reset ticks. The next tick comes no earlier than evaluation 589,680.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe for a new ratio pair |
| ratio_a_i | input | RATIO_W | Denominator a (unsigned) |
| ratio_b_i | input | RATIO_W | Numerator b (unsigned) |
| tick_o | output | 1 | Registered one-cycle enable pulse |

## Verification
The bound checker watches, on every cycle, the limits of the error register, the clearing and blanking caused by an accepted load, the unchanged pair after a rejected load, the reset state, and single-cycle pulses at ratios of one half or below. Only the bench scenarios can show that the pulse pattern matches the floor-based formula, that a window of a cycles holds exactly b pulses, and that gaps stay within floor/ceil of a/b. To do this the bench sweeps every pair with a ≤ 16 and adds boundary pairs at b = 1 and b = a − 1. A rejected load in the middle of a stream must leave the formula undisturbed. The default configuration is run alongside the sweep.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // next-state selection for the error register
  typedef enum logic [1:0] {
    ACC_CLEAR  = 2'd0,
    ACC_ADD_UP = 2'd1,
    ACC_ADD_DN = 2'd2
  } acc_op_e;

endpackage

// File: rtl/frac_ratio_reg.sv
module frac_ratio_reg #(
  parameter int RATIO_W = 24,
  parameter int ACC_W   = RATIO_W + 1,
  parameter int DEF_A   = 14152300,
  parameter int DEF_B   = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic [RATIO_W-1:0]       a_i,
  input  logic [RATIO_W-1:0]       b_i,
  output logic                     accept_o,
  output logic [RATIO_W-1:0]       cfg_a_o,
  output logic [RATIO_W-1:0]       cfg_b_o,
  output logic signed [ACC_W-1:0]  step_up_o,
  output logic signed [ACC_W-1:0]  step_dn_o
);

  localparam logic [RATIO_W-1:0] DEF_A_V = RATIO_W'(DEF_A);
  localparam logic [RATIO_W-1:0] DEF_B_V = RATIO_W'(DEF_B);

  logic pair_ok;

  // only 0 < b < a is accepted
  assign pair_ok  = (b_i != '0) && (b_i < a_i);
  assign accept_o = load_i && pair_ok;

  // both increments are precomputed at capture so the loop holds one adder
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a_o   <= DEF_A_V;
      cfg_b_o   <= DEF_B_V;
      step_up_o <= $signed({1'b0, DEF_B_V});
      step_dn_o <= $signed({1'b0, DEF_B_V}) - $signed({1'b0, DEF_A_V});
    end else if (accept_o) begin
      cfg_a_o   <= a_i;
      cfg_b_o   <= b_i;
      step_up_o <= $signed({1'b0, b_i});
      step_dn_o <= $signed({1'b0, b_i}) - $signed({1'b0, a_i});
    end
  end

endmodule

// File: rtl/frac_err_acc.sv
module frac_err_acc
  import frac_tick_pkg::*;
#(
  parameter int ACC_W = 25
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_i,
  input  logic signed [ACC_W-1:0]  step_up_i,
  input  logic signed [ACC_W-1:0]  step_dn_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     nonneg_o
);

  acc_op_e                 op;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;

  always_comb begin
    if (clear_i)                op = ACC_CLEAR;
    else if (acc_q[ACC_W-1])    op = ACC_ADD_UP;
    else                        op = ACC_ADD_DN;
  end

  always_comb begin
    case (op)
      ACC_ADD_UP: acc_d = acc_q + step_up_i;
      ACC_ADD_DN: acc_d = acc_q + step_dn_i;
      default:    acc_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign acc_o    = acc_q;
  assign nonneg_o = ~acc_q[ACC_W-1];

endmodule

// File: rtl/frac_tick_out.sv
module frac_tick_out (
  input  logic clk,
  input  logic rst,
  input  logic blank_i,
  input  logic nonneg_i,
  output logic tick_o
);

  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst || blank_i) tick_q <= 1'b0;
    else                tick_q <= nonneg_i;
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int RATIO_W = 24,
  parameter int DEF_A   = 14152300,
  parameter int DEF_B   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_a_i,
  input  logic [RATIO_W-1:0] ratio_b_i,
  output logic               tick_o
);

  localparam int ACC_W = RATIO_W + 1;

  logic                    accept;
  logic [RATIO_W-1:0]      cfg_a;
  logic [RATIO_W-1:0]      cfg_b;
  logic signed [ACC_W-1:0] step_up;
  logic signed [ACC_W-1:0] step_dn;
  logic signed [ACC_W-1:0] acc_q;
  logic                    nonneg;

  frac_ratio_reg #(
    .RATIO_W (RATIO_W),
    .ACC_W   (ACC_W),
    .DEF_A   (DEF_A),
    .DEF_B   (DEF_B)
  ) u_ratio (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .a_i       (ratio_a_i),
    .b_i       (ratio_b_i),
    .accept_o  (accept),
    .cfg_a_o   (cfg_a),
    .cfg_b_o   (cfg_b),
    .step_up_o (step_up),
    .step_dn_o (step_dn)
  );

  frac_err_acc #(
    .ACC_W (ACC_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (accept),
    .step_up_i (step_up),
    .step_dn_i (step_dn),
    .acc_o     (acc_q),
    .nonneg_o  (nonneg)
  );

  frac_tick_out u_out (
    .clk      (clk),
    .rst      (rst),
    .blank_i  (accept),
    .nonneg_i (nonneg),
    .tick_o   (tick_o)
  );

endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int RATIO_W = 24,
  parameter int DEF_A   = 14152300,
  parameter int DEF_B   = 24,
  parameter int ACC_W   = RATIO_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load_i,
  input logic [RATIO_W-1:0]      ratio_a_i,
  input logic [RATIO_W-1:0]      ratio_b_i,
  input logic signed [ACC_W-1:0] acc_q,
  input logic [RATIO_W-1:0]      cfg_a,
  input logic [RATIO_W-1:0]      cfg_b,
  input logic                    tick_o
);

  logic signed [ACC_W-1:0] lo_s;
  logic signed [ACC_W-1:0] hi_s;
  logic                    good_load;
  logic                    bad_load;
  logic                    half_or_less;

  assign lo_s         = $signed({1'b0, cfg_b}) - $signed({1'b0, cfg_a});
  assign hi_s         = $signed({1'b0, cfg_b}) - $signed(ACC_W'(1));
  assign good_load    = load_i && (ratio_b_i != '0) && (ratio_b_i < ratio_a_i);
  assign bad_load     = load_i && !((ratio_b_i != '0) && (ratio_b_i < ratio_a_i));
  assign half_or_less = ({cfg_b, 1'b0} <= {1'b0, cfg_a});

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !tick_o && (cfg_a == RATIO_W'(DEF_A)) && (cfg_b == RATIO_W'(DEF_B)));

  // R3: error register bounded by [b-a, b-1]
  p_acc_range_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= lo_s) && (acc_q <= hi_s));

  // R6: accepted load clears and blanks
  p_load_clear_r6: assert property (@(posedge clk) disable iff (rst)
    good_load |=> (acc_q == '0) && !tick_o && (cfg_a == $past(ratio_a_i)) && (cfg_b == $past(ratio_b_i)));

  // R7: rejected load keeps the pair
  p_reject_keep_r7: assert property (@(posedge clk) disable iff (rst)
    bad_load |=> $stable(cfg_a) && $stable(cfg_b));

  // R8: single-cycle pulses at ratios of one half or below
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_o && half_or_less && !load_i) |=> !tick_o);

endmodule

bind frac_tick_gen frac_tick_gen_chk #(
  .RATIO_W (RATIO_W),
  .DEF_A   (DEF_A),
  .DEF_B   (DEF_B)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_i    (load_i),
  .ratio_a_i (ratio_a_i),
  .ratio_b_i (ratio_b_i),
  .acc_q     (acc_q),
  .cfg_a     (cfg_a),
  .cfg_b     (cfg_b),
  .tick_o    (tick_o)
);

// File: tb/tb_frac_tick_gen.sv
module tb_frac_tick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         tick_o;
  logic         ref_tick;

  int errors = 0;
  int checks = 0;
  int win_ticks;
  int last_tick;
  int ref_count = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_tick_gen #(.RATIO_W(W), .DEF_A(10), .DEF_B(3)) dut (
    .clk(clk), .rst(rst), .load_i(load_i),
    .ratio_a_i(a_in), .ratio_b_i(b_in), .tick_o(tick_o)
  );

  // default configuration, the large reference ratio
  frac_tick_gen dref (
    .clk(clk), .rst(rst), .load_i(1'b0),
    .ratio_a_i(24'd0), .ratio_b_i(24'd0), .tick_o(ref_tick)
  );

  always @(negedge clk) if (!rst && ref_tick) ref_count++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_tick(input longint k, input longint a, input longint b);
    if (k == 0) return 1'b1;
    return ((k * b) / a) != (((k - 1) * b) / a);
  endfunction

  task automatic start_pair();
    win_ticks = 0;
    last_tick = -1;
  endtask

  // sample evaluations k0 .. k0+n-1, one per falling edge
  task automatic run(input int a, input int b, input int k0, input int n);
    for (int k = k0; k < k0 + n; k++) begin
      bit e;
      @(negedge clk);
      e = exp_tick(k, a, b);
      check(tick_o == e, "R2/R4 tick pattern", int'(tick_o), int'(e));
      if (tick_o) begin
        if (k < a) win_ticks++;
        if (last_tick >= 0)
          check(((k - last_tick) == a / b) || ((k - last_tick) == (a + b - 1) / b),
                "R5 gap", k - last_tick, a / b);
        last_tick = k;
      end
      if (k == a - 1) check(win_ticks == b, "R4 window count", win_ticks, b);
    end
  endtask

  task automatic load_pair(input int a, input int b);
    @(negedge clk);
    load_i = 1'b1; a_in = W'(a); b_in = W'(b);
    @(negedge clk);
    check(tick_o == 1'b0, "R6 blank after load", int'(tick_o), 0);
    load_i = 1'b0;
    start_pair();
    run(a, b, 0, 2 * a + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tick_o == 1'b0, "R1 reset tick", int'(tick_o), 0);
    check(ref_tick == 1'b0, "R1 reset tick ref", int'(ref_tick), 0);
    rst = 1'b0;
    start_pair();
    // default pair 10/3 after reset; first sample also checks the big default
    run(10, 3, 0, 1);
    check(ref_tick == 1'b1, "R9 first tick", int'(ref_tick), 1);
    run(10, 3, 1, 14);
    // R7: rejected loads in mid-stream (b=0, then b>=a)
    load_i = 1'b1; a_in = 8'd9; b_in = 8'd0;
    run(10, 3, 15, 1);
    a_in = 8'd5; b_in = 8'd5;
    run(10, 3, 16, 1);
    a_in = 8'd3; b_in = 8'd9;
    run(10, 3, 17, 1);
    load_i = 1'b0;
    run(10, 3, 18, 12);  // R7 continuity check
    // exhaustive sweep over small pairs, includes b=1 and b=a-1
    for (int a = 2; a <= 16; a++)
      for (int b = 1; b < a; b++)
        load_pair(a, b);
    load_pair(255, 1);
    load_pair(255, 254);
    load_pair(200, 7);
    load_pair(128, 64);
    // R9: no second tick of the default configuration within this run
    check(ref_count == 1, "R9 reference tick count", ref_count, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule